// File: doc/BRIEF.md
# Counter Clock and Gate Router

This block sits in front of a ring of counter groups, each group holding three 16-bit counter channels. For every channel it picks a counting clock and a gate from a small set of candidates, under control of two 3-bit selection fields that software writes over a simple register bus. The counters themselves live elsewhere. Their outputs come back into this block, so that one channel can clock or gate a neighbouring one. The chaining crosses group boundaries, and the last group wraps around to the first.

Clock candidates are the channel's own clock pin, five internal timebases derived from the block clock, the output of the preceding channel, and a clock pin shared by the three channels of a group. Gate candidates are a constant enable, a constant disable, the channel's own gate pin, and the inverted output of the channel two positions back. For each channel the block also controls the direction of its clock and gate pins. A pin is an input only while it is the selected source. Otherwise the block drives the pin with the clock or gate it has selected. Every selection field can be read back.

The block clock is taken as the fastest timebase (nominally 10 MHz). The slower timebases are single-cycle enable pulses from a decade divider chain.

Top module: `ctr_clk_gate_router`

## Requirements
- R1: After reset every clock selection and every gate selection is 0. All clock pins are therefore inputs, every channel's gate is held enabled (1), and all gate pins are driven.
- R2: With clock code 0 a channel's clock follows its own clock pin and that pin's output enable is 0. With any other clock code the output enable is 1 and the pin output carries the selected clock.
- R3: Clock codes 1 to 5 select enable pulses with periods of 1, 10, 100, 1000 and 10000 block-clock cycles. Each pulse is one cycle wide. Counting k rising edges since reset release, code c is high when (k+1) is a multiple of 10^(c-1).
- R4: Clock code 6 selects the counter output of flat channel i-1, modulo the channel count. Flat channel i is group g, channel n, with i = 3g+n. Channel 0 of group 0 therefore takes channel 2 of the last group.
- R5: Clock code 7 selects the shared clock pin of the channel's own group (pin g for channels 3g to 3g+2).
- R6: Gate code 0 gives a constant 1 and code 1 a constant 0. Gate code 2 follows the channel's own gate pin with that pin's output enable at 0. With every gate code other than 2 the gate pin output enable is 1 and the pin output carries the selected gate.
- R7: Gate code 3 selects the inverted counter output of flat channel i-2, modulo the channel count. This is the same group's channel 0 for n=2, and channel n+1 of the preceding group for n<2, wrapping from group 0 to the last group.
- R8: Gate codes 4 to 7 give a gate of 0. Reading such a field returns the written code unchanged.
- R9: Register address bit 0 picks the gate field (1) or the clock field (0). The bits above it give the flat channel index. A write takes effect at the next rising edge. Reads are combinational. A read of a channel index at or beyond the channel count returns 0.
- R10: A write to a channel index at or beyond the channel count changes no selection and no routed output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the fastest timebase |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address {channel, field} |
| wr_data | input | 3 | Selection code to write |
| rd_addr | input | AW | Read address {channel, field} |
| rd_data | output | 3 | Selection code at rd_addr |
| grp_clk_in | input | NUM_GROUPS | Shared clock pin of each group |
| cnt_out | input | NCH | Counter outputs, flat channel order |
| clk_pin_in | input | NCH | Per-channel clock pin, input value |
| clk_pin_out | output | NCH | Per-channel clock pin, driven value |
| clk_pin_oe | output | NCH | Per-channel clock pin output enable |
| gate_pin_in | input | NCH | Per-channel gate pin, input value |
| gate_pin_out | output | NCH | Per-channel gate pin, driven value |
| gate_pin_oe | output | NCH | Per-channel gate pin output enable |
| chan_clk | output | NCH | Selected clock of each channel |
| chan_gate | output | NCH | Selected gate of each channel |

## Verification
The chaining codes are driven with a one-hot value walked across all counter outputs. Each position shows which neighbour a channel listens to, in which direction, and that the wrap from group 0 reaches the last group. The shared group clocks are raised one at a time, which separates the two groups. The own-pin codes use complementary pin patterns, which separate a routed pin from a constant. The timebases are watched every cycle over two periods of the slowest one, which checks pulse spacing and single-cycle width together. Reserved gate codes are tried with all counter outputs low, so a wrong fall into the inverted-output path would show as a 1.

// File: rtl/ctr_route_pkg.sv
`timescale 1ns/1ps
package ctr_route_pkg;

    localparam int SEL_W        = 3;
    localparam int NUM_TB       = 5;
    localparam int CH_PER_GROUP = 3;

    typedef logic [SEL_W-1:0] sel_t;

    typedef enum logic [SEL_W-1:0] {
        CK_PIN     = 3'd0,
        CK_TB_10M  = 3'd1,
        CK_TB_1M   = 3'd2,
        CK_TB_100K = 3'd3,
        CK_TB_10K  = 3'd4,
        CK_TB_1K   = 3'd5,
        CK_PREV    = 3'd6,
        CK_GROUP   = 3'd7
    } clk_code_e;

    typedef enum logic [SEL_W-1:0] {
        GT_ON   = 3'd0,
        GT_OFF  = 3'd1,
        GT_PIN  = 3'd2,
        GT_INV2 = 3'd3
    } gate_code_e;

endpackage

// File: rtl/ctr_route_timebase.sv
`timescale 1ns/1ps
module ctr_route_timebase #(
    parameter int RADIX  = 10,
    parameter int STAGES = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [STAGES:0] tick
);
    localparam int CW = $clog2(RADIX);
    localparam logic [CW-1:0] LAST = CW'(RADIX - 1);

    typedef struct packed {
        logic [STAGES-1:0][CW-1:0] cnt;
    } tb_state_t;

    tb_state_t st_d, st_q;

    always_comb begin
        logic run;
        st_d    = st_q;
        run     = 1'b1;
        tick[0] = 1'b1;
        for (int k = 0; k < STAGES; k++) begin
            if (run) begin
                st_d.cnt[k] = (st_q.cnt[k] == LAST) ? '0 : CW'(st_q.cnt[k] + CW'(1));
            end
            run         = run && (st_q.cnt[k] == LAST);
            tick[k + 1] = run;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/ctr_route_selregs.sv
`timescale 1ns/1ps
module ctr_route_selregs
    import ctr_route_pkg::*;
#(
    parameter int NCH  = 6,
    parameter int CH_W = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [CH_W:0]             wr_addr,
    input  sel_t                      wr_data,
    input  logic [CH_W:0]             rd_addr,
    output sel_t                      rd_data,
    output logic [NCH-1:0][SEL_W-1:0] clk_sel,
    output logic [NCH-1:0][SEL_W-1:0] gate_sel
);
    typedef struct packed {
        logic [NCH-1:0][SEL_W-1:0] ck;
        logic [NCH-1:0][SEL_W-1:0] gt;
    } sel_state_t;

    sel_state_t st_d, st_q;

    logic [CH_W-1:0] wr_ch;
    logic [CH_W-1:0] rd_ch;

    assign wr_ch = wr_addr[CH_W:1];
    assign rd_ch = rd_addr[CH_W:1];

    always_comb begin
        st_d = st_q;
        for (int c = 0; c < NCH; c++) begin
            if (wr_en && (int'(wr_ch) == c)) begin
                if (wr_addr[0]) begin
                    st_d.gt[c] = wr_data;
                end else begin
                    st_d.ck[c] = wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int c = 0; c < NCH; c++) begin
            if (int'(rd_ch) == c) begin
                rd_data = rd_addr[0] ? st_q.gt[c] : st_q.ck[c];
            end
        end
    end

    assign clk_sel  = st_q.ck;
    assign gate_sel = st_q.gt;

endmodule

// File: rtl/ctr_route_chan_mux.sv
`timescale 1ns/1ps
module ctr_route_chan_mux
    import ctr_route_pkg::*;
(
    input  sel_t              clk_sel,
    input  sel_t              gate_sel,
    input  logic [NUM_TB-1:0] tb_tick,
    input  logic              pin_clk,
    input  logic              pin_gate,
    input  logic              prev_out,
    input  logic              back2_out,
    input  logic              grp_clk,
    output logic              sel_clk,
    output logic              sel_gate,
    output logic              clk_drive,
    output logic              gate_drive
);
    always_comb begin
        case (clk_sel)
            CK_PIN:     sel_clk = pin_clk;
            CK_TB_10M:  sel_clk = tb_tick[0];
            CK_TB_1M:   sel_clk = tb_tick[1];
            CK_TB_100K: sel_clk = tb_tick[2];
            CK_TB_10K:  sel_clk = tb_tick[3];
            CK_TB_1K:   sel_clk = tb_tick[4];
            CK_PREV:    sel_clk = prev_out;
            default:    sel_clk = grp_clk;
        endcase
    end

    always_comb begin
        case (gate_sel)
            GT_ON:   sel_gate = 1'b1;
            GT_OFF:  sel_gate = 1'b0;
            GT_PIN:  sel_gate = pin_gate;
            GT_INV2: sel_gate = ~back2_out;
            default: sel_gate = 1'b0;
        endcase
    end

    assign clk_drive  = (clk_sel != CK_PIN);
    assign gate_drive = (gate_sel != GT_PIN);

endmodule

// File: rtl/ctr_clk_gate_router.sv
`timescale 1ns/1ps
module ctr_clk_gate_router
    import ctr_route_pkg::*;
#(
    parameter int NUM_GROUPS = 2,
    parameter int TB_RADIX   = 10,
    localparam int NCH       = NUM_GROUPS * CH_PER_GROUP,
    localparam int CH_W      = $clog2(NCH),
    localparam int AW        = CH_W + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [AW-1:0]         wr_addr,
    input  logic [SEL_W-1:0]      wr_data,
    input  logic [AW-1:0]         rd_addr,
    output logic [SEL_W-1:0]      rd_data,
    input  logic [NUM_GROUPS-1:0] grp_clk_in,
    input  logic [NCH-1:0]        cnt_out,
    input  logic [NCH-1:0]        clk_pin_in,
    output logic [NCH-1:0]        clk_pin_out,
    output logic [NCH-1:0]        clk_pin_oe,
    input  logic [NCH-1:0]        gate_pin_in,
    output logic [NCH-1:0]        gate_pin_out,
    output logic [NCH-1:0]        gate_pin_oe,
    output logic [NCH-1:0]        chan_clk,
    output logic [NCH-1:0]        chan_gate
);
    logic [NUM_TB-1:0]         tb_tick;
    logic [NCH-1:0][SEL_W-1:0] clk_sel_v;
    logic [NCH-1:0][SEL_W-1:0] gate_sel_v;

    ctr_route_timebase #(
        .RADIX  (TB_RADIX),
        .STAGES (NUM_TB - 1)
    ) i_timebase (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tb_tick)
    );

    ctr_route_selregs #(
        .NCH  (NCH),
        .CH_W (CH_W)
    ) i_selregs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .clk_sel  (clk_sel_v),
        .gate_sel (gate_sel_v)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        localparam int PREV_IDX  = (i + NCH - 1) % NCH;
        localparam int BACK2_IDX = (i + NCH - 2) % NCH;
        localparam int GRP_IDX   = i / CH_PER_GROUP;

        ctr_route_chan_mux i_mux (
            .clk_sel    (clk_sel_v[i]),
            .gate_sel   (gate_sel_v[i]),
            .tb_tick    (tb_tick),
            .pin_clk    (clk_pin_in[i]),
            .pin_gate   (gate_pin_in[i]),
            .prev_out   (cnt_out[PREV_IDX]),
            .back2_out  (cnt_out[BACK2_IDX]),
            .grp_clk    (grp_clk_in[GRP_IDX]),
            .sel_clk    (chan_clk[i]),
            .sel_gate   (chan_gate[i]),
            .clk_drive  (clk_pin_oe[i]),
            .gate_drive (gate_pin_oe[i])
        );

        assign clk_pin_out[i]  = clk_pin_oe[i] & chan_clk[i];
        assign gate_pin_out[i] = gate_pin_oe[i] & chan_gate[i];
    end

endmodule

// File: rtl/ctr_route_chk.sv
`timescale 1ns/1ps
module ctr_route_chk
    import ctr_route_pkg::*;
#(
    parameter int NCH = 6,
    parameter int AW  = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      wr_en,
    input logic [AW-1:0]             wr_addr,
    input logic [SEL_W-1:0]          wr_data,
    input logic [NCH-1:0]            cnt_out,
    input logic [NCH-1:0]            clk_pin_in,
    input logic [NCH-1:0]            clk_pin_oe,
    input logic [NCH-1:0]            gate_pin_in,
    input logic [NCH-1:0]            gate_pin_oe,
    input logic [NCH-1:0]            chan_clk,
    input logic [NCH-1:0]            chan_gate,
    input logic [NUM_TB-1:0]         tb_tick,
    input logic [NCH-1:0][SEL_W-1:0] clk_sel,
    input logic [NCH-1:0][SEL_W-1:0] gate_sel
);
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam int PREV_IDX  = (i + NCH - 1) % NCH;
        localparam int BACK2_IDX = (i + NCH - 2) % NCH;

        assert_clk_pin_in_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !clk_pin_oe[i] |-> (chan_clk[i] == clk_pin_in[i]));

        assert_clk_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
            clk_pin_oe[i] == (clk_sel[i] != CK_PIN));

        assert_clk_prev_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (clk_sel[i] == CK_PREV) |-> (chan_clk[i] == cnt_out[PREV_IDX]));

        assert_gate_pin_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (gate_sel[i] == GT_PIN) |-> (!gate_pin_oe[i] && (chan_gate[i] == gate_pin_in[i])));

        assert_gate_inv_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (gate_sel[i] == GT_INV2) |-> (chan_gate[i] == !cnt_out[BACK2_IDX]));

        assert_gate_rsvd_R8: assert property (@(posedge clk) disable iff (!rst_n)
            gate_sel[i][2] |-> !chan_gate[i]);

        assert_wr_clk_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (wr_addr == AW'(2 * i))) |=> (clk_sel[i] == $past(wr_data)));

        assert_wr_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (wr_addr == AW'(2 * i + 1))) |=> (gate_sel[i] == $past(wr_data)));
    end

    for (genvar k = 1; k < NUM_TB; k++) begin : g_tb
        assert_tick_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
            tb_tick[k] |=> !tb_tick[k]);

        assert_tick_nest_R3: assert property (@(posedge clk) disable iff (!rst_n)
            tb_tick[k] |-> tb_tick[k - 1]);
    end

endmodule

bind ctr_clk_gate_router ctr_route_chk #(
    .NCH (NCH),
    .AW  (AW)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .cnt_out     (cnt_out),
    .clk_pin_in  (clk_pin_in),
    .clk_pin_oe  (clk_pin_oe),
    .gate_pin_in (gate_pin_in),
    .gate_pin_oe (gate_pin_oe),
    .chan_clk    (chan_clk),
    .chan_gate   (chan_gate),
    .tb_tick     (tb_tick),
    .clk_sel     (clk_sel_v),
    .gate_sel    (gate_sel_v)
);

// File: tb/test_ctr_clk_gate_router.sv
`timescale 1ns/1ps
module test_ctr_clk_gate_router;
    import ctr_route_pkg::*;

    localparam int NG  = 2;
    localparam int NCH = NG * CH_PER_GROUP;
    localparam int AW  = $clog2(NCH) + 1;

    localparam int K_CLK      = 0;
    localparam int K_GATE     = 1;
    localparam int K_CLK_OE   = 2;
    localparam int K_GATE_OE  = 3;
    localparam int K_CLK_OUT  = 4;
    localparam int K_GATE_OUT = 5;
    localparam int K_RD       = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [AW-1:0]   wr_addr = '0;
    logic [2:0]      wr_data = '0;
    logic [AW-1:0]   rd_addr = '0;
    logic [2:0]      rd_data;
    logic [NG-1:0]   grp_clk_in = '0;
    logic [NCH-1:0]  cnt_out = '0;
    logic [NCH-1:0]  clk_pin_in = '0;
    logic [NCH-1:0]  clk_pin_out;
    logic [NCH-1:0]  clk_pin_oe;
    logic [NCH-1:0]  gate_pin_in = '0;
    logic [NCH-1:0]  gate_pin_out;
    logic [NCH-1:0]  gate_pin_oe;
    logic [NCH-1:0]  chan_clk;
    logic [NCH-1:0]  chan_gate;

    ctr_clk_gate_router #(.NUM_GROUPS(NG)) i_ctr_clk_gate_router (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .grp_clk_in(grp_clk_in), .cnt_out(cnt_out),
        .clk_pin_in(clk_pin_in), .clk_pin_out(clk_pin_out), .clk_pin_oe(clk_pin_oe),
        .gate_pin_in(gate_pin_in), .gate_pin_out(gate_pin_out), .gate_pin_oe(gate_pin_oe),
        .chan_clk(chan_clk), .chan_gate(chan_gate)
    );

    always #10 clk = ~clk;

    // reference state, kept from the requirements only
    int         cyc = 0;
    logic [2:0] m_ck [NCH];
    logic [2:0] m_gt [NCH];
    int         n_checks = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    typedef struct {
        string       req;
        int          kind;
        logic [15:0] exp;
    } item_t;
    item_t sb[$];

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    function automatic logic ref_clk(int i);
        int code = int'(m_ck[i]);
        int pw = 1;
        case (code)
            0: return clk_pin_in[i];
            6: return cnt_out[(i + NCH - 1) % NCH];
            7: return grp_clk_in[i / CH_PER_GROUP];
            default: begin
                for (int s = 1; s < code; s++) pw = pw * 10;
                return ((cyc + 1) % pw) == 0;
            end
        endcase
    endfunction

    function automatic logic ref_gate(int i);
        case (int'(m_gt[i]))
            0: return 1'b1;
            1: return 1'b0;
            2: return gate_pin_in[i];
            3: return !cnt_out[(i + NCH - 2) % NCH];
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [15:0] ref_vec(int kind);
        logic [15:0] v = '0;
        int ch = int'(rd_addr >> 1);
        for (int i = 0; i < NCH; i++) begin
            case (kind)
                K_CLK:      v[i] = ref_clk(i);
                K_GATE:     v[i] = ref_gate(i);
                K_CLK_OE:   v[i] = (m_ck[i] != 3'd0);
                K_GATE_OE:  v[i] = (m_gt[i] != 3'd2);
                K_CLK_OUT:  v[i] = (m_ck[i] != 3'd0) && ref_clk(i);
                K_GATE_OUT: v[i] = (m_gt[i] != 3'd2) && ref_gate(i);
                default:    v[i] = 1'b0;
            endcase
        end
        if (kind == K_RD) begin
            v = '0;
            if (ch < NCH) v[2:0] = rd_addr[0] ? m_gt[ch] : m_ck[ch];
        end
        return v;
    endfunction

    function automatic logic [15:0] observe(int kind);
        logic [15:0] v = '0;
        case (kind)
            K_CLK:      v[NCH-1:0] = chan_clk;
            K_GATE:     v[NCH-1:0] = chan_gate;
            K_CLK_OE:   v[NCH-1:0] = clk_pin_oe;
            K_GATE_OE:  v[NCH-1:0] = gate_pin_oe;
            K_CLK_OUT:  v[NCH-1:0] = clk_pin_out;
            K_GATE_OUT: v[NCH-1:0] = gate_pin_out;
            default:    v[2:0] = rd_data;
        endcase
        return v;
    endfunction

    // monitor: pops expected items and compares away from the edge
    always @(negedge clk) begin
        #2;
        while (sb.size() > 0) begin
            item_t it;
            logic [15:0] got;
            it  = sb.pop_front();
            got = observe(it.kind);
            n_checks++;
            if (got !== it.exp) begin
                n_fail++;
                $display("FAIL %s kind=%0d cycle=%0d actual=%h expected=%h",
                         it.req, it.kind, cyc, got, it.exp);
            end
        end
    end

    // driver side
    task automatic chk(string req, int kind);
        item_t it;
        it.req  = req;
        it.kind = kind;
        it.exp  = ref_vec(kind);
        sb.push_back(it);
        @(negedge clk);
    endtask

    task automatic wr(int ch, bit is_gate, logic [2:0] code);
        wr_en   = 1'b1;
        wr_addr = AW'({ch[AW-2:0], is_gate});
        wr_data = code;
        @(negedge clk);
        wr_en = 1'b0;
        if (ch < NCH) begin
            if (is_gate) m_gt[ch] = code;
            else         m_ck[ch] = code;
        end
    endtask

    task automatic read_all(string req);
        for (int a = 0; a < (1 << AW); a++) begin
            rd_addr = AW'(a);
            chk(req, K_RD);
        end
    endtask

    initial begin
        for (int i = 0; i < NCH; i++) begin
            m_ck[i] = 3'd0;
            m_gt[i] = 3'd0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        clk_pin_in  = 6'b101010;
        gate_pin_in = 6'b010101;
        chk("R1", K_CLK);
        chk("R1", K_CLK_OE);
        chk("R1", K_GATE);
        chk("R1", K_GATE_OE);
        read_all("R1");

        // R2: own clock pin versus driven pin
        wr(1, 0, 3'd1);
        wr(4, 0, 3'd1);
        chk("R2", K_CLK_OE);
        chk("R2", K_CLK_OUT);
        clk_pin_in = 6'b010101;
        chk("R2", K_CLK);
        chk("R2", K_CLK_OUT);

        // R5: shared group clock, one group at a time
        wr(1, 0, 3'd7);
        wr(2, 0, 3'd7);
        wr(4, 0, 3'd7);
        grp_clk_in = 2'b01;
        chk("R5", K_CLK);
        grp_clk_in = 2'b10;
        chk("R5", K_CLK);
        chk("R5", K_CLK_OUT);
        grp_clk_in = 2'b00;

        // R4: previous-channel chaining with ring wrap
        for (int i = 0; i < NCH; i++) wr(i, 0, 3'd6);
        for (int k = 0; k < NCH; k++) begin
            cnt_out = NCH'(1) << k;
            chk("R4", K_CLK);
        end

        // R7: inverted output two channels back with ring wrap
        for (int i = 0; i < NCH; i++) wr(i, 1, 3'd3);
        for (int k = 0; k < NCH; k++) begin
            cnt_out = NCH'(1) << k;
            chk("R7", K_GATE);
        end
        chk("R7", K_GATE_OE);
        chk("R7", K_GATE_OUT);

        // R6: constant and pin gates
        wr(0, 1, 3'd0);
        wr(1, 1, 3'd1);
        wr(2, 1, 3'd2);
        wr(3, 1, 3'd2);
        wr(4, 1, 3'd0);
        wr(5, 1, 3'd1);
        gate_pin_in = 6'b000100;
        chk("R6", K_GATE);
        chk("R6", K_GATE_OE);
        chk("R6", K_GATE_OUT);
        gate_pin_in = 6'b111011;
        chk("R6", K_GATE);

        // R8: reserved gate codes read back and hold the gate low
        cnt_out = '0;
        wr(0, 1, 3'd4);
        wr(1, 1, 3'd5);
        wr(2, 1, 3'd6);
        wr(3, 1, 3'd7);
        chk("R8", K_GATE);
        chk("R8", K_GATE_OUT);
        read_all("R8");

        // R9 / R10: address map and out-of-range writes
        wr(5, 0, 3'd2);
        wr(5, 1, 3'd3);
        wr(6, 0, 3'd5);
        wr(7, 1, 3'd3);
        wr(7, 0, 3'd1);
        read_all("R9");
        chk("R10", K_CLK);
        chk("R10", K_GATE);
        chk("R10", K_CLK_OE);

        // R3: timebases, every cycle over two slow periods
        cnt_out = '0;
        clk_pin_in = '0;
        for (int i = 0; i < 5; i++) wr(i, 0, 3'(i + 1));
        wr(5, 0, 3'd3);
        for (int n = 0; n < 20010; n++) chk("R3", K_CLK);
        chk("R3", K_CLK_OUT);

        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R1..all actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule